// File: doc/BRIEF.md
# Branch-to-Predicate Compare Unit

This unit sits just after instruction decode. It watches conditional branch encodings in both the full 32-bit form and the 16-bit compressed form. When a branch names a vectorised source register and its target register is tagged as a predicate, the branch is not taken as control flow. Instead it becomes a per-element compare, and the result is written as one bit of a predicate register held inside the unit. In the repurposed encodings, the field that used to carry the branch offset now names that predicate register.

An external sequencer supplies element indices and operand values on one or more lanes. The unit returns the decoded source register numbers so that the operands can be read. It evaluates the compare for every valid lane and updates the selected bits in a single cycle. Any predicate register can be read back through a combinational read port.

A branch that does not meet the vector/predicate conditions raises a pass-through flag and leaves all state alone, so ordinary branching carries on.

Top module: `branch_pred_unit`

## Requirements
- R1: After reset every bit of every predicate register reads back as 0.
- R2: A full-size compare is recognised when instr[1:0]=11 and instr[6:0]=1100011, with funct3 = instr[14:12] taking one of these values: 000 (equal), 001 (not equal), 100 (signed less-than), 101 (signed greater-or-equal), 110 (unsigned less-than) or 111 (unsigned greater-or-equal). Source 1 is instr[19:15], source 2 is instr[24:20] and the target predicate register is instr[11:7]. Bits 31..25 are reserved and have no effect.
- R3: A compressed compare is recognised when instr[1:0]=01 and instr[15:13] is 110 or 111. The target is 8+instr[12:10], source 1 is 8+instr[9:7] and source 2 is 8+instr[4:2]. The compare kind is {instr[13],instr[5]}: 00 equal, 01 not equal, 10 less-than, 11 less-or-equal. instr[6]=1 selects the unsigned path and raises src_fp. instr[6]=0 selects the signed path. instr[31:16] are ignored.
- R4: Greater-than and greater-or-equal in compressed form are obtained by swapping the source fields of less-than and less-or-equal. The unit then reports the swapped register numbers and evaluates the swapped compare.
- R5: In predicate mode, each valid lane writes its compare result (1 = true) to bit lane_idx of the target register. The new value is visible on rd_data one clock edge after the request. Predicate mode is: in_valid, a recognised compare, at least one source register set in vec_tag, and the target register set in pred_tag.
- R6: A predicate-mode write changes no bit of the target register other than the bits at the indices of valid lanes.
- R7: A recognised compare with in_valid that is not in predicate mode raises pass_thru, keeps pred_wr low and changes no predicate state.
- R8: Lanes are applied in ascending lane order within one cycle. If two valid lanes name the same bit, the higher-numbered lane's result stands. A lane with lane_vld=0 writes nothing.
- R9: With in_valid low, or for any encoding that is not a recognised compare, both pass_thru and pred_wr stay low and the predicate state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word (compressed form in low 16 bits) |
| vec_tag | input | NREG | Per-register vectorised flag |
| pred_tag | input | NREG | Per-register predicate flag |
| src1_sel | output | RW | Decoded source 1 register number |
| src2_sel | output | RW | Decoded source 2 register number |
| src_fp | output | 1 | Compressed compare selects the floating/unsigned path |
| lane_vld | input | LANES | Per-lane element valid |
| lane_idx | input | LANES*IW | Per-lane element index |
| lane_a | input | LANES*XLEN | Per-lane source 1 element value |
| lane_b | input | LANES*XLEN | Per-lane source 2 element value |
| pass_thru | output | 1 | Branch proceeds as a normal branch |
| pred_wr | output | 1 | Predicate update this cycle |
| rd_sel | input | RW | Predicate register read select |
| rd_data | output | XLEN | Predicate register read data |

## Verification
The hardest situation to create from the ports is two lanes in one cycle that name the same bit with opposite results. This is the only case where the ordering rule is visible. The stimulus drives both lane orders against a shared index and reads the bit back each time. It also pairs a valid lane with an invalid lane whose result would differ. Separately, the stimulus sets a bit and later clears it with a false compare, so writes are shown to clear as well as set.

// File: rtl/branch_pred_unit.sv
module branch_pred_unit #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int LANES = 2,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(XLEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [31:0]           instr,
  input  logic [NREG-1:0]       vec_tag,
  input  logic [NREG-1:0]       pred_tag,
  output logic [RW-1:0]         src1_sel,
  output logic [RW-1:0]         src2_sel,
  output logic                  src_fp,
  input  logic [LANES-1:0]      lane_vld,
  input  logic [LANES*IW-1:0]   lane_idx,
  input  logic [LANES*XLEN-1:0] lane_a,
  input  logic [LANES*XLEN-1:0] lane_b,
  output logic                  pass_thru,
  output logic                  pred_wr,
  input  logic [RW-1:0]         rd_sel,
  output logic [XLEN-1:0]       rd_data
);

  typedef enum logic [2:0] {K_EQ, K_NE, K_LT, K_GE, K_LE} kind_t;

  logic                      is_c, f_hit, c_hit, hit, uns, pred_mode;
  logic [RW-1:0]             pdst;
  kind_t                     kind;
  logic [LANES-1:0]          lres;
  logic [NREG-1:0][XLEN-1:0] pbank;
  logic [XLEN-1:0]           cur_row, row_nxt, touch;

  assign is_c  = instr[1:0] != 2'b11;
  assign f_hit = !is_c && instr[6:0] == 7'b1100011 && instr[14:13] != 2'b01;
  assign c_hit = instr[1:0] == 2'b01 && instr[15:14] == 2'b11;
  assign hit   = f_hit || c_hit;

  assign src1_sel = is_c ? RW'(8) + RW'(instr[9:7])   : RW'(instr[19:15]);
  assign src2_sel = is_c ? RW'(8) + RW'(instr[4:2])   : RW'(instr[24:20]);
  assign pdst     = is_c ? RW'(8) + RW'(instr[12:10]) : RW'(instr[11:7]);
  assign src_fp   = c_hit && instr[6];
  assign uns      = is_c ? instr[6] : instr[13];

  always_comb begin
    if (is_c) begin
      case ({instr[13], instr[5]})
        2'b00:   kind = K_EQ;
        2'b01:   kind = K_NE;
        2'b10:   kind = K_LT;
        default: kind = K_LE;
      endcase
    end else begin
      case ({instr[14], instr[12]})
        2'b00:   kind = K_EQ;
        2'b01:   kind = K_NE;
        2'b10:   kind = K_LT;
        default: kind = K_GE;
      endcase
    end
  end

  assign pred_mode = in_valid && hit && (vec_tag[src1_sel] || vec_tag[src2_sel]) && pred_tag[pdst];
  assign pred_wr   = pred_mode;
  assign pass_thru = in_valid && hit && !pred_mode;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [XLEN-1:0] a, b;
    logic            eq, lt;
    assign a  = lane_a[l*XLEN +: XLEN];
    assign b  = lane_b[l*XLEN +: XLEN];
    assign eq = a == b;
    assign lt = uns ? (a < b) : ($signed(a) < $signed(b));
    always_comb begin
      case (kind)
        K_EQ:    lres[l] = eq;
        K_NE:    lres[l] = !eq;
        K_LT:    lres[l] = lt;
        K_GE:    lres[l] = !lt;
        default: lres[l] = lt || eq;
      endcase
    end
  end

  assign cur_row = pbank[pdst];

  always_comb begin
    row_nxt = cur_row;
    touch   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l]) begin
        row_nxt[lane_idx[l*IW +: IW]] = lres[l];
        touch[lane_idx[l*IW +: IW]]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pbank <= '0;
    else if (pred_wr) pbank[pdst] <= row_nxt;
  end

  assign rd_data = pbank[rd_sel];

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_thru && pred_wr)) else $error("mode overlap"); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_wr |=> $stable(pbank)) else $error("state moved without write"); // R7

  AST_UNTOUCHED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wr |=> ((pbank[$past(pdst)] ^ $past(cur_row)) & ~$past(touch)) == '0)
    else $error("foreign bit changed"); // R6

  AST_C_REGMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_hit) |-> (src1_sel >= RW'(8) && src1_sel < RW'(16) && src2_sel >= RW'(8) && src2_sel < RW'(16)))
    else $error("compressed source out of window"); // R3

  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pred_wr |-> in_valid) else $error("write without valid"); // R9

endmodule

// File: tb/tb_branch_pred_unit.sv
module tb_branch_pred_unit;
  localparam int XLEN = 32, NREG = 32, LANES = 2, RW = 5, IW = 5;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = '0;
  logic [NREG-1:0] vec_tag = 32'h0000_FF0E, pred_tag = 32'h0010_1000;
  logic [RW-1:0] src1_sel, src2_sel, rd_sel = '0;
  logic src_fp, pass_thru, pred_wr;
  logic [LANES-1:0] lane_vld = '0;
  logic [LANES*IW-1:0] lane_idx = '0;
  logic [LANES*XLEN-1:0] lane_a = '0, lane_b = '0;
  logic [XLEN-1:0] rd_data;

  int errors = 0, checks = 0;
  logic [31:0] model [NREG];

  always #2 clk = ~clk;

  branch_pred_unit #(.XLEN(XLEN), .NREG(NREG), .LANES(LANES)) dut (
    .clk, .rst_n, .in_valid, .instr, .vec_tag, .pred_tag, .src1_sel, .src2_sel, .src_fp,
    .lane_vld, .lane_idx, .lane_a, .lane_b, .pass_thru, .pred_wr, .rd_sel, .rd_data);

  typedef struct packed {
    logic c; logic [2:0] code; logic fp;
    logic [4:0] s1, s2, pd;
    logic [31:0] a, b;
    logic [4:0] idx; logic exp;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{1'b0, 3'b000, 1'b0, 5'd1, 5'd2, 5'd20, 32'd5, 32'd5, 5'd3, 1'b1},
    '{1'b0, 3'b001, 1'b0, 5'd1, 5'd2, 5'd20, 32'd5, 32'd5, 5'd4, 1'b0},
    '{1'b0, 3'b100, 1'b0, 5'd1, 5'd2, 5'd20, 32'hFFFFFFFF, 32'd1, 5'd5, 1'b1},
    '{1'b0, 3'b110, 1'b0, 5'd1, 5'd2, 5'd20, 32'hFFFFFFFF, 32'd1, 5'd6, 1'b0},
    '{1'b0, 3'b101, 1'b0, 5'd1, 5'd2, 5'd20, 32'd7, 32'd7, 5'd7, 1'b1},
    '{1'b0, 3'b111, 1'b0, 5'd1, 5'd2, 5'd20, 32'd1, 32'hFFFFFFFF, 5'd8, 1'b0},
    '{1'b0, 3'b000, 1'b0, 5'd1, 5'd2, 5'd20, 32'd1, 32'd2, 5'd3, 1'b0},
    '{1'b0, 3'b100, 1'b0, 5'd3, 5'd2, 5'd20, 32'h80000000, 32'h7FFFFFFF, 5'd31, 1'b1},
    '{1'b1, 3'b000, 1'b0, 5'd0, 5'd1, 5'd4, 32'd9, 32'd9, 5'd0, 1'b1},
    '{1'b1, 3'b001, 1'b0, 5'd0, 5'd1, 5'd4, 32'd1, 32'd2, 5'd1, 1'b1},
    '{1'b1, 3'b010, 1'b0, 5'd0, 5'd1, 5'd4, 32'hFFFFFFFE, 32'd3, 5'd2, 1'b1},
    '{1'b1, 3'b011, 1'b0, 5'd0, 5'd1, 5'd4, 32'd3, 32'd3, 5'd3, 1'b1},
    '{1'b1, 3'b010, 1'b1, 5'd0, 5'd1, 5'd4, 32'hFFFFFFFE, 32'd3, 5'd4, 1'b0},
    '{1'b1, 3'b011, 1'b1, 5'd0, 5'd1, 5'd4, 32'd4, 32'd3, 5'd5, 1'b0},
    '{1'b1, 3'b010, 1'b0, 5'd1, 5'd0, 5'd4, 32'd2, 32'd10, 5'd6, 1'b1}
  };

  function automatic logic [31:0] enc(vec_t v);
    if (!v.c) enc = {7'd0, v.s2, v.s1, v.code, v.pd, 7'b1100011};
    else      enc = {16'h0, 2'b11, v.code[1], v.pd[2:0], v.s1[2:0], v.fp, v.code[0], v.s2[2:0], 2'b01};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readback(input string req, input int r);
    rd_sel = RW'(r);
    #1 chk(req, rd_data, model[r]);
  endtask

  task automatic issue(input logic [31:0] ins, input logic [1:0] vld,
                       input logic [4:0] i0, input logic [31:0] a0, input logic [31:0] b0,
                       input logic [4:0] i1, input logic [31:0] a1, input logic [31:0] b1);
    @(negedge clk);
    in_valid = 1; instr = ins; lane_vld = vld;
    lane_idx = {i1, i0}; lane_a = {a1, a0}; lane_b = {b1, b0};
    #1;
  endtask

  task automatic retire;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; lane_vld = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    readback("R1", 20);
    readback("R1", 12);
    readback("R1", 0);

    for (int e = 0; e < 15; e++) begin
      automatic vec_t v = TBL[e];
      automatic int pr = v.c ? 8 + int'(v.pd[2:0]) : int'(v.pd);
      automatic logic [4:0] e1 = v.c ? 5'(8 + v.s1[2:0]) : v.s1;
      automatic logic [4:0] e2 = v.c ? 5'(8 + v.s2[2:0]) : v.s2;
      issue(enc(v), 2'b01, v.idx, v.a, v.b, 5'd0, 32'd0, 32'd0);
      chk(v.c ? (e == 14 ? "R4" : "R3") : "R2", {22'd0, src1_sel, src2_sel}, {22'd0, e1, e2});
      chk(v.c ? "R3" : "R2", {30'd0, src_fp, pred_wr}, {30'd0, v.c & v.fp, 1'b1});
      retire();
      model[pr][v.idx] = v.exp;
      readback(e == 6 ? "R6" : "R5", pr);
    end

    // R2 reserved bits ignored
    issue({7'h7F, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}, 2'b01, 5'd9, 32'd4, 32'd4, 5'd0, 0, 0);
    retire(); model[20][9] = 1'b1; readback("R2", 20);
    // R3 upper half ignored for compressed
    issue({16'hBEEF, 16'({2'b11, 1'b0, 3'd4, 3'd0, 1'b0, 1'b0, 3'd1, 2'b01})}, 2'b01, 5'd10, 32'd6, 32'd6, 5'd0, 0, 0);
    chk("R3", {31'd0, pred_wr}, 32'd1);
    retire(); model[12][10] = 1'b1; readback("R3", 12);

    // R7 non-vector sources
    issue({7'd0, 5'd5, 5'd4, 3'b000, 5'd20, 7'b1100011}, 2'b01, 5'd11, 32'd1, 32'd1, 5'd0, 0, 0);
    chk("R7", {30'd0, pass_thru, pred_wr}, 32'd2);
    retire(); readback("R7", 20);
    // R7 untagged target
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd21, 7'b1100011}, 2'b01, 5'd0, 32'd1, 32'd1, 5'd0, 0, 0);
    chk("R7", {30'd0, pass_thru, pred_wr}, 32'd2);
    retire(); readback("R7", 21);

    // R9 non-compare encodings and idle
    issue({7'd0, 5'd2, 5'd1, 3'b010, 5'd20, 7'b1100011}, 2'b01, 5'd12, 32'd1, 32'd1, 5'd0, 0, 0);
    chk("R9", {30'd0, pass_thru, pred_wr}, 32'd0);
    retire(); readback("R9", 20);
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b0110011}, 2'b01, 5'd12, 32'd1, 32'd1, 5'd0, 0, 0);
    chk("R9", {30'd0, pass_thru, pred_wr}, 32'd0);
    retire();
    issue({16'h0, 3'b100, 3'd4, 3'd0, 2'b00, 3'd1, 2'b01}, 2'b01, 5'd12, 32'd1, 32'd1, 5'd0, 0, 0);
    chk("R9", {30'd0, pass_thru, pred_wr}, 32'd0);
    retire(); readback("R9", 12);
    @(negedge clk);
    instr = {7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}; lane_vld = 2'b11;
    lane_idx = {5'd13, 5'd12}; lane_a = '0; lane_b = '0;
    #1 chk("R9", {30'd0, pass_thru, pred_wr}, 32'd0);
    retire(); readback("R9", 20);

    // R8 lanes
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}, 2'b11, 5'd14, 32'd1, 32'd1, 5'd15, 32'd1, 32'd2);
    retire(); model[20][14] = 1'b1; model[20][15] = 1'b0; readback("R8", 20);
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}, 2'b11, 5'd16, 32'd1, 32'd1, 5'd16, 32'd1, 32'd2);
    retire(); model[20][16] = 1'b0; readback("R8", 20);
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}, 2'b11, 5'd17, 32'd1, 32'd2, 5'd17, 32'd1, 32'd1);
    retire(); model[20][17] = 1'b1; readback("R8", 20);
    issue({7'd0, 5'd2, 5'd1, 3'b000, 5'd20, 7'b1100011}, 2'b01, 5'd18, 32'd1, 32'd2, 5'd19, 32'd1, 32'd1);
    retire(); model[20][18] = 1'b0; readback("R8", 20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule